// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Interval Timer

The block is a general-purpose interval timer whose count is a 16-bit counter widened by an 8-bit prescale extension, so that the whole count behaves as one 24-bit value. It counts either up or down. In one-shot mode it stops and drops its own enable after the first time-out. In periodic mode it reloads and carries on. Each time-out produces a one-cycle trigger pulse and sets a sticky status bit. A match event, which can be switched on, sets a second sticky status bit. Both bits are masked onto one interrupt line and are cleared by writing 1 to a clear register.

Software drives the block through a one-cycle write strobe carrying an address and data, and reads it through a combinational read port. Start can be held back until an external trigger arrives. A debug-halt input freezes counting when the stall option is selected. Writes to the interval value and to the match value can be applied at once or deferred to the next time-out. In periodic mode with snapshot selected, the counter value at every time-out is captured into a readable register.

Top module: `gp_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, snapshot, status, enable and mask all read 0, and `irq` and `tmo_pulse` are low.
- R2: The configuration register is written at address 0. Its fields are mode in bits 1:0 (value 2 = periodic, any other value = one-shot), up-count in bit 2, wait-for-trigger in bit 3, snapshot in bit 4, match-enable in bit 5, deferred-load in bit 6, deferred-match in bit 7 and stall in bit 8. Writing 1 to bit 0 of address 1 while the timer is stopped starts it: an up-count starts from 0 and a down-count starts from the interval value. Read address 3 returns the enable bit.
- R3: A down-count times out at 0 and reloads the interval value (address 2) on the next edge. An up-count times out when the count equals the interval value and reloads 0. Each time-out gives a one-cycle `tmo_pulse` in the cycle after the time-out edge.
- R4: In one-shot mode the time-out clears the enable bit and counting stops. In periodic mode counting continues.
- R5: With wait-for-trigger set, a started timer holds its start value until `trig` is sampled high, and then counts.
- R6: Only in periodic mode with the snapshot bit set, each time-out copies the count into the snapshot register (read address 1). In one-shot mode the snapshot register is left unchanged.
- R7: Read address 2 returns the status as bit 0 raw time-out, bit 1 raw match, bit 2 masked time-out and bit 3 masked match. Time-out always sets raw bit 0. Writing 1 to address 6 bit 0 or bit 1 clears the corresponding raw bit. An event in the same cycle as its clear leaves the bit set. The mask is at address 5 (bit 0 time-out, bit 1 match), and `irq` is high when any masked bit is set.
- R8: A match fires when the running count equals the active match value (written at address 3). Raw bit 1 is set only while the match-enable bit is 1.
- R9: Writing the interval value while counting down with deferred-load clear loads the count on the next edge. With deferred-load set, the new value is used only at the next reload. While counting up, the new value becomes the time-out limit on the next edge.
- R10: Writing address 4 loads the count on the next edge in either direction. This takes priority over counting.
- R11: With deferred-match clear, a match write becomes active on the next edge. With deferred-match set, it becomes active only at the next time-out.
- R12: With stall set and `dbg_halt` high, the count is frozen. Without stall, `dbg_halt` has no effect.
- R13: The count is one 24-bit value: the prescale extension forms the upper 8 bits, and a borrow or carry crosses the 16-bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 24 | Read data (combinational) |
| trig | input | 1 | Start trigger for wait-for-trigger mode |
| dbg_halt | input | 1 | Debug halt, freezes counting when stall is set |
| irq | output | 1 | OR of the masked status bits |
| tmo_pulse | output | 1 | One-cycle pulse per time-out |

## Verification
The bench aims at the cycles where two things meet. One is a clear written in the same cycle as a time-out: a design that let the clear win would lose an interrupt. Another is a write to the interval or match value that has to wait for the next time-out: applying it early moves the period or the match point, and the per-cycle count comparison shows this at once. The bench also checks one-shot self-disable and a snapshot left untouched in one-shot mode, start held by wait-for-trigger, the stall freeze, and a borrow across the 16-bit boundary, which a design that split the two counters wrongly would get wrong.

// File: rtl/gpt_pkg.sv
// Shared definitions for the interval timer: configuration layout,
// register addresses and the mode encoding. Assumes a single writer.
package gpt_pkg;
    // Configuration word, bit 0 is the LSB of mode.
    typedef struct packed {
        logic       stall;        // bit 8
        logic       defer_match;  // bit 7
        logic       defer_load;   // bit 6
        logic       match_ie;     // bit 5
        logic       snap;         // bit 4
        logic       wait_trig;    // bit 3
        logic       up;           // bit 2
        logic [1:0] mode;         // bits 1:0
    } cfg_t;

    localparam int CFG_W = 9;

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_CTRL  = 3'd1;
    localparam logic [2:0] A_LOAD  = 3'd2;
    localparam logic [2:0] A_MATCH = 3'd3;
    localparam logic [2:0] A_VALUE = 3'd4;
    localparam logic [2:0] A_MASK  = 3'd5;
    localparam logic [2:0] A_CLR   = 3'd6;

    localparam logic [2:0] R_VALUE = 3'd0;
    localparam logic [2:0] R_SNAP  = 3'd1;
    localparam logic [2:0] R_STAT  = 3'd2;
    localparam logic [2:0] R_CTRL  = 3'd3;

    localparam logic [1:0] MODE_PERIODIC = 2'd2;
endpackage

// File: rtl/gpt_regs.sv
// Register bank: decodes the write port and holds configuration,
// interval, pending match and mask. Assumes wr_data is at least CFG_W wide.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output cfg_t         cfg,
    output logic [W-1:0] load_q,
    output logic [W-1:0] match_q,
    output logic [1:0]   mask_q,
    output logic         we_ctrl,
    output logic         we_load,
    output logic         we_match,
    output logic         we_value,
    output logic [1:0]   clr
);
    logic we_cfg, we_mask;

    // Address decode of the single write strobe.
    always_comb begin
        we_cfg   = wr_en && (wr_addr == A_CFG);
        we_ctrl  = wr_en && (wr_addr == A_CTRL);
        we_load  = wr_en && (wr_addr == A_LOAD);
        we_match = wr_en && (wr_addr == A_MATCH);
        we_value = wr_en && (wr_addr == A_VALUE);
        we_mask  = wr_en && (wr_addr == A_MASK);
        clr      = (wr_en && (wr_addr == A_CLR)) ? wr_data[1:0] : 2'b00;
    end

    // Storage of the software-visible settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            load_q  <= '0;
            match_q <= '0;
            mask_q  <= '0;
        end else begin
            if (we_cfg)   cfg     <= cfg_t'(wr_data[CFG_W-1:0]);
            if (we_load)  load_q  <= wr_data;
            if (we_match) match_q <= wr_data;
            if (we_mask)  mask_q  <= wr_data[1:0];
        end
    end
endmodule

// File: rtl/gpt_core.sv
// Counting engine: enable and trigger state, the combined counter,
// reload and time-out, active match value and snapshot capture.
// Assumes at most one register write per cycle.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cfg_t         cfg,
    input  logic [W-1:0] load_q,
    input  logic [W-1:0] match_q,
    input  logic [W-1:0] wdata,
    input  logic         ctrl_bit,
    input  logic         we_ctrl,
    input  logic         we_load,
    input  logic         we_match,
    input  logic         we_value,
    input  logic         trig,
    input  logic         halt,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] snap_q,
    output logic         en_q,
    output logic         tmo,
    output logic         mat
);
    logic         trg_q;
    logic [W-1:0] mact_q;
    logic         periodic, step, start, load_imm;

    // Event and qualifier decode for the current cycle.
    always_comb begin
        periodic = (cfg.mode == MODE_PERIODIC);
        step     = en_q && trg_q && !(cfg.stall && halt);
        start    = we_ctrl && ctrl_bit && !en_q;
        load_imm = we_load && !cfg.up && !cfg.defer_load && en_q;
        tmo      = step && (cfg.up ? (cnt_q == load_q) : (cnt_q == '0));
        mat      = step && (cnt_q == mact_q);
    end

    // Counter with write, start, reload and count priority.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (we_value)     cnt_q <= wdata;
        else if (load_imm)     cnt_q <= wdata;
        else if (start || tmo) cnt_q <= cfg.up ? '0 : load_q;
        else if (step)         cnt_q <= cfg.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    // Enable bit and trigger arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            trg_q <= 1'b0;
        end else begin
            if (we_ctrl)             en_q <= ctrl_bit;
            else if (tmo && !periodic) en_q <= 1'b0;
            if (start)               trg_q <= !cfg.wait_trig;
            else if (en_q && trig)   trg_q <= 1'b1;
        end
    end

    // Active match value and time-out snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mact_q <= '0;
            snap_q <= '0;
        end else begin
            if (we_match && !cfg.defer_match) mact_q <= wdata;
            else if (tmo && cfg.defer_match)  mact_q <= match_q;
            if (tmo && periodic && cfg.snap)  snap_q <= cnt_q;
        end
    end

    // R4: one-shot time-out drops the enable.
    a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !periodic && !we_ctrl) |=> !en_q);
    // R3: down-count reloads the interval value after time-out.
    a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !cfg.up && !we_value && !load_imm) |=> (cnt_q == $past(load_q)));
    // R12: stall with halt holds the count.
    a_r12_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.stall && halt && !we_value && !load_imm && !we_ctrl) |=> $stable(cnt_q));
    // R10: value write lands on the next edge.
    a_r10_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        we_value |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/gpt_status.sv
// Sticky raw status with write-1-clear, masking and the time-out pulse.
// Assumes events and clears arrive as single-cycle strobes.
module gpt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmo,
    input  logic       mat,
    input  logic       match_ie,
    input  logic [1:0] clr,
    input  logic [1:0] mask_q,
    output logic [3:0] stat,
    output logic       irq,
    output logic       tmo_pulse
);
    logic raw_t, raw_m;

    // Raw bits: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_t     <= 1'b0;
            raw_m     <= 1'b0;
            tmo_pulse <= 1'b0;
        end else begin
            raw_t     <= tmo | (raw_t & ~clr[0]);
            raw_m     <= (mat & match_ie) | (raw_m & ~clr[1]);
            tmo_pulse <= tmo;
        end
    end

    // Masked view and interrupt line.
    always_comb begin
        stat = {raw_m & mask_q[1], raw_t & mask_q[0], raw_m, raw_t};
        irq  = |stat[3:2];
    end

    // R7: raw time-out stays set until cleared.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_t && !clr[0]) |=> raw_t);
    // R8: no match status while match-enable is low.
    a_r8_match_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_m && !match_ie) |=> !raw_m);
endmodule

// File: rtl/gp_timer.sv
// Top of the interval timer: wires register bank, counting engine and
// status, and drives the combinational read port. Assumes one write per cycle.
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             wr_addr,
    input  logic [CNT_W+PRE_W-1:0] wr_data,
    input  logic [2:0]             rd_addr,
    output logic [CNT_W+PRE_W-1:0] rd_data,
    input  logic                   trig,
    input  logic                   dbg_halt,
    output logic                   irq,
    output logic                   tmo_pulse
);
    localparam int W = CNT_W + PRE_W;

    cfg_t         cfg;
    logic [W-1:0] load_q, match_q, cnt_q, snap_q;
    logic [1:0]   mask_q, clr;
    logic         we_ctrl, we_load, we_match, we_value;
    logic         en_q, tmo, mat;
    logic [3:0]   stat;

    gpt_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .load_q(load_q), .match_q(match_q),
        .mask_q(mask_q), .we_ctrl(we_ctrl), .we_load(we_load),
        .we_match(we_match), .we_value(we_value), .clr(clr)
    );

    gpt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .load_q(load_q),
        .match_q(match_q), .wdata(wr_data), .ctrl_bit(wr_data[0]),
        .we_ctrl(we_ctrl), .we_load(we_load), .we_match(we_match),
        .we_value(we_value), .trig(trig), .halt(dbg_halt),
        .cnt_q(cnt_q), .snap_q(snap_q), .en_q(en_q), .tmo(tmo), .mat(mat)
    );

    gpt_status u_stat (
        .clk(clk), .rst_n(rst_n), .tmo(tmo), .mat(mat),
        .match_ie(cfg.match_ie), .clr(clr), .mask_q(mask_q),
        .stat(stat), .irq(irq), .tmo_pulse(tmo_pulse)
    );

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            R_VALUE: rd_data = cnt_q;
            R_SNAP:  rd_data = snap_q;
            R_STAT:  rd_data = {{(W-4){1'b0}}, stat};
            R_CTRL:  rd_data = {{(W-1){1'b0}}, en_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;
    localparam int MSK = 24'hFFFFFF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [23:0] wr_data = 0;
    logic [2:0]  rd_addr = 0;
    logic [23:0] rd_data;
    logic        trig = 0;
    logic        dbg_halt = 0;
    logic        irq, tmo_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gp_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig(trig), .dbg_halt(dbg_halt), .irq(irq), .tmo_pulse(tmo_pulse)
    );

    // Behavioural reference state.
    int m_cnt, m_load, m_mq, m_mact, m_snap, m_cfg;
    bit m_en, m_trg, m_rt, m_rm, m_pulse;
    bit [1:0] m_mask;

    task automatic chk(input string name, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", name, got, exp);
        end
    endtask

    // Reference model, one update per clock edge.
    always @(posedge clk) begin
        int n_cnt;
        bit up_d, per, step, tmo, mat, start, wc, wl, wm, wv;
        bit [1:0] clrv;
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_mq = 0; m_mact = 0; m_snap = 0; m_cfg = 0;
            m_en = 0; m_trg = 0; m_rt = 0; m_rm = 0; m_pulse = 0; m_mask = 0;
        end else begin
            up_d  = m_cfg[2];
            per   = ((m_cfg & 3) == 2);
            step  = m_en && m_trg && !(m_cfg[8] && dbg_halt);
            tmo   = step && (up_d ? (m_cnt == m_load) : (m_cnt == 0));
            mat   = step && (m_cnt == m_mact);
            wc    = wr_en && wr_addr == 1;
            wl    = wr_en && wr_addr == 2;
            wm    = wr_en && wr_addr == 3;
            wv    = wr_en && wr_addr == 4;
            clrv  = (wr_en && wr_addr == 6) ? wr_data[1:0] : 2'b00;
            start = wc && wr_data[0] && !m_en;
            n_cnt = m_cnt;
            if (wv) n_cnt = int'(wr_data);
            else if (wl && !up_d && !m_cfg[6] && m_en) n_cnt = int'(wr_data);
            else if (start || tmo) n_cnt = up_d ? 0 : m_load;
            else if (step) n_cnt = up_d ? ((m_cnt + 1) & MSK) : ((m_cnt - 1) & MSK);
            if (tmo && per && m_cfg[4]) m_snap = m_cnt;
            if (wm && !m_cfg[7]) m_mact = int'(wr_data);
            else if (tmo && m_cfg[7]) m_mact = m_mq;
            if (start) m_trg = !m_cfg[3];
            else if (m_en && trig) m_trg = 1;
            if (wc) m_en = wr_data[0];
            else if (tmo && !per) m_en = 0;
            m_rt = tmo || (m_rt && !clrv[0]);
            m_rm = (mat && m_cfg[5]) || (m_rm && !clrv[1]);
            m_pulse = tmo;
            m_cnt = n_cnt;
            if (wr_en && wr_addr == 0) m_cfg = int'(wr_data) & 'h1FF;
            if (wl) m_load = int'(wr_data);
            if (wm) m_mq = int'(wr_data);
            if (wr_en && wr_addr == 5) m_mask = wr_data[1:0];
        end
    end

    // Per-cycle comparison just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3 R9 R10 R12 R13 cycle count", int'(rd_data), m_cnt);
            chk("R3 cycle tmo_pulse", int'(tmo_pulse), int'(m_pulse));
            chk("R7 cycle irq", int'(irq), int'(((m_rt & m_mask[0]) | (m_rm & m_mask[1]))));
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d[23:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic peek(input logic [2:0] a, output int d);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        d = int'(rd_data);
        rd_addr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog expired got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        peek(3'd0, v); chk("R1 count after reset", v, 0);
        peek(3'd1, v); chk("R1 snapshot after reset", v, 0);
        peek(3'd2, v); chk("R1 status after reset", v, 0);
        peek(3'd3, v); chk("R1 enable after reset", v, 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R6 R2 periodic up with snapshot
        wr(3'd5, 1);
        wr(3'd0, 'h16);
        wr(3'd2, 4);
        wr(3'd1, 1);
        peek(3'd3, v); chk("R2 enable reads 1", v, 1);
        idle(12);
        peek(3'd1, v); chk("R6 snapshot at up time-out", v, 4);
        peek(3'd2, v); chk("R7 raw and masked time-out", v & 5, 5);
        wr(3'd1, 0);
        wr(3'd6, 1);
        peek(3'd2, v); chk("R7 status cleared by write-1", v, 0);

        // R4 R6 one-shot up, snapshot bit ignored
        wr(3'd0, 'h15);
        wr(3'd2, 3);
        wr(3'd1, 1);
        idle(8);
        peek(3'd3, v); chk("R4 one-shot cleared enable", v, 0);
        peek(3'd0, v); chk("R4 one-shot count parked at 0", v, 0);
        peek(3'd1, v); chk("R6 snapshot unchanged in one-shot", v, 4);
        wr(3'd6, 3);

        // R5 wait for trigger, periodic down
        wr(3'd0, 'h0A);
        wr(3'd2, 10);
        wr(3'd1, 1);
        idle(5);
        peek(3'd0, v); chk("R5 held until trigger", v, 10);
        @(negedge clk); trig = 1;
        @(negedge clk); trig = 0;
        idle(3);
        peek(3'd0, v); chk("R5 counting after trigger", int'(v < 10), 1);
        wr(3'd1, 0);

        // R8 match gated by enable bit
        wr(3'd5, 3);
        wr(3'd6, 3);
        wr(3'd0, 'h06);
        wr(3'd2, 20);
        wr(3'd3, 5);
        wr(3'd1, 1);
        idle(10);
        peek(3'd2, v); chk("R8 no match status while disabled", v & 2, 0);
        wr(3'd0, 'h26);
        idle(25);
        peek(3'd2, v); chk("R8 match status set", v & 'hA, 'hA);
        wr(3'd1, 0);
        wr(3'd6, 3);

        // R7 clear coincides with time-out: event wins
        wr(3'd0, 'h02);
        wr(3'd2, 0);
        wr(3'd1, 1);
        idle(3);
        wr(3'd6, 1);
        peek(3'd2, v); chk("R7 event beats clear", v & 1, 1);
        wr(3'd1, 0);
        wr(3'd6, 3);

        // R9 immediate and deferred interval load while counting down
        wr(3'd2, 50);
        wr(3'd1, 1);
        idle(5);
        wr(3'd2, 100);
        peek(3'd0, v); chk("R9 immediate load taken", int'(v >= 98 && v <= 100), 1);
        wr(3'd0, 'h42);
        wr(3'd2, 7);
        peek(3'd0, v); chk("R9 deferred load not applied early", int'(v > 7), 1);
        idle(120);
        // R9 up-count limit change
        wr(3'd0, 'h06);
        wr(3'd2, 9);
        idle(25);

        // R10 value write
        wr(3'd0, 'h02);
        wr(3'd4, 'h123);
        peek(3'd0, v); chk("R10 value write loaded", int'(v >= 'h121 && v <= 'h123), 1);
        wr(3'd1, 0);

        // R11 deferred match update
        wr(3'd0, 'h26);
        wr(3'd3, 40);
        wr(3'd0, 'hA6);
        wr(3'd3, 12);
        wr(3'd2, 30);
        wr(3'd6, 3);
        wr(3'd1, 1);
        idle(16);
        peek(3'd2, v); chk("R11 deferred match inactive before time-out", v & 2, 0);
        idle(35);
        peek(3'd2, v); chk("R11 deferred match active after time-out", v & 2, 2);
        wr(3'd1, 0);
        wr(3'd6, 3);

        // R12 stall freeze and halt ignored without stall
        wr(3'd0, 'h102);
        wr(3'd2, 200);
        wr(3'd1, 1);
        @(negedge clk); dbg_halt = 1;
        peek(3'd0, v);
        idle(5);
        chk("R12 frozen under halt", int'(rd_data), v);
        @(negedge clk); dbg_halt = 0;
        idle(4);
        wr(3'd0, 'h002);
        @(negedge clk); dbg_halt = 1;
        peek(3'd0, v);
        idle(3);
        chk("R12 halt ignored without stall", int'(rd_data), v - 3);
        @(negedge clk); dbg_halt = 0;

        // R13 borrow across 16-bit boundary
        wr(3'd2, 'hFFFFFF);
        wr(3'd4, 'h010001);
        idle(2);
        chk("R13 borrow into prescale bits", int'(rd_data), 'h00FFFF);
        wr(3'd1, 0);
        idle(3);

        done = 1;
        summary();
        $finish;
    end
endmodule